// File: doc/BRIEF.md
# Sectioned Memory Parity Guard

This block sits between a bus-side access port and a byte-parity memory array. On every write it computes one parity bit per data byte and hands it to the array together with per-lane write strobes. On every read it checks the returned data against the returned parity bits and, when a section allows it, raises a one-cycle halt or trap request and records where the fault happened.

The 128K-word address space is split into sixteen 8K sections. Each section has one configuration register: the access address bits [16:13] select the register and bit 12 selects the lower or upper 4K half. Each half has its own odd/even sense. Enable and halt/trap choice apply to the whole section. Reads are checked against the sense in force at read time. Software can therefore flip a sense bit after data was written and force errors on purpose. A strap input marks the attached storage as having no parity bits, which turns off generation and checking entirely.

Top module: `parity_guard`

## Requirements
- R1: After reset every configuration register reads 0x0000 (checking off, trap mode, even parity in both halves), `haltReq` and `trapReq` are low and `errAddr` is 0.
- R2: A register write stores bits 0 (enable), 1 (1 = halt, 0 = trap), 2 (odd sense, lower 4K) and 3 (odd sense, upper 4K). Bits 4..14 always read 0. `regRdData` shows register `regSel` combinationally.
- R3: In the same cycle as a write access, `memWrPar[i]` equals the XOR of byte i of `accWrData`, inverted when the odd bit of the addressed half is set. The register is chosen by `accAddr[16:13]` and the half by `accAddr[12]` (0 = lower).
- R4: `memWe[i]` is high in the same cycle exactly when `accValid`, `accWrite` and `accByteEn[i]` are all high, so a byte write touches only its own lane's data and parity bit.
- R5: A read access whose section is enabled raises a request in the cycle after the access when, for either lane, the XOR of the data byte and its parity bit differs from the odd sense of the addressed half. A clean read or any write raises no request.
- R6: A detected error pulses `haltReq` when the section's bit 1 is 1 and `trapReq` when it is 0. The two are never high together.
- R7: A read from a section whose enable bit is 0 never raises a request, whatever its parity.
- R8: With `parityStrap` low, `memWrPar` is 0 and no read raises a request or sets a sticky flag.
- R9: A detected error sets bit 15 of its section's register. Writing 1 to bit 15 clears it and writing 0 leaves it. An error in the same cycle as a clearing write leaves it set.
- R10: `errAddr` takes the full address of the failing read in the same cycle the request appears, and holds it until the next error.
- R11: Data written under one parity sense reads back as an error after that half's sense bit is inverted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| parityStrap | input | 1 | 1 = storage carries parity bits; 0 = no parity, all generation and checking off |
| regSel | input | 4 | Configuration register index for read and write |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 16 | Register write data |
| regRdData | output | 16 | Contents of the selected register |
| accValid | input | 1 | Memory access present this cycle |
| accWrite | input | 1 | 1 = write access, 0 = read access |
| accAddr | input | 17 | Word address of the access |
| accByteEn | input | 2 | Byte lanes written |
| accWrData | input | 16 | Write data from the bus |
| memWe | output | 2 | Per-lane write strobe to the array |
| memWrPar | output | 2 | Generated parity bit per lane |
| memRdData | input | 16 | Read data from the array, valid in the access cycle |
| memRdPar | input | 2 | Stored parity bits from the array, valid in the access cycle |
| haltReq | output | 1 | One-cycle halt request on an error |
| trapReq | output | 1 | One-cycle trap request on an error |
| errAddr | output | 17 | Address of the most recent failing read |

## Verification
`memWe`, `memWrPar` and `regRdData` are combinational, so the bench samples them a moment after it drives the inputs, in the same low clock phase. `haltReq`, `trapReq`, `errAddr` and the sticky flags all come from one register stage and are due one cycle after the read. The bench drives a read on a falling edge, lets one rising edge pass, and samples these results on the next falling edge, while the pulse is still high. Fault injection is done by feeding back the parity captured at write time with chosen lanes flipped, or by changing the sense between write and read.

// File: rtl/parity_guard_pkg.sv
package parity_guard_pkg;
  localparam int DATA_W     = 16;
  localparam int LANES      = DATA_W / 8;
  localparam int REG_W      = 16;
  localparam int BIT_EN     = 0;
  localparam int BIT_HALT   = 1;
  localparam int BIT_ODD_LO = 2;
  localparam int BIT_ODD_HI = 3;
  localparam int BIT_STICKY = REG_W - 1;

  // Strobes from control to datapath for the current access
  typedef struct packed {
    logic             genEn;     // parity generation allowed
    logic             chkEn;     // check this read
    logic             oddSense;  // sense of the addressed 4K half
    logic [LANES-1:0] laneWe;    // per-lane write strobes
  } dpStrobe_t;
endpackage

// File: rtl/parity_guard_dp.sv
module parity_guard_dp
  import parity_guard_pkg::*;
(
  input  dpStrobe_t         strb,
  input  logic [DATA_W-1:0] accWrData,
  input  logic [DATA_W-1:0] memRdData,
  input  logic [LANES-1:0]  memRdPar,
  output logic [LANES-1:0]  memWe,
  output logic [LANES-1:0]  memWrPar,
  output logic [LANES-1:0]  laneErr
);
  assign memWe = strb.laneWe;

  for (genvar l = 0; l < LANES; l++) begin : gLane
    logic [7:0] wrByte;
    logic [7:0] rdByte;
    logic       rdOnes;
    assign wrByte      = accWrData[l*8 +: 8];
    assign rdByte      = memRdData[l*8 +: 8];
    assign rdOnes      = ^rdByte ^ memRdPar[l];
    assign memWrPar[l] = strb.genEn & ((^wrByte) ^ strb.oddSense);
    assign laneErr[l]  = strb.chkEn & (rdOnes != strb.oddSense);
  end
endmodule

// File: rtl/parity_guard_ctrl.sv
module parity_guard_ctrl
  import parity_guard_pkg::*;
#(
  parameter int ADDR_W   = 17,
  parameter int NUM_SECT = 16
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        parityStrap,
  input  logic [$clog2(NUM_SECT)-1:0] regSel,
  input  logic                        regWrEn,
  input  logic [REG_W-1:0]            regWrData,
  output logic [REG_W-1:0]            regRdData,
  input  logic                        accValid,
  input  logic                        accWrite,
  input  logic [ADDR_W-1:0]           accAddr,
  input  logic [LANES-1:0]            accByteEn,
  input  logic [LANES-1:0]            laneErr,
  output dpStrobe_t                   strb,
  output logic                        haltReq,
  output logic                        trapReq,
  output logic [ADDR_W-1:0]           errAddr
);
  localparam int SEL_W    = $clog2(NUM_SECT);
  localparam int SECT_LSB = ADDR_W - SEL_W;
  localparam int BLK_BIT  = SECT_LSB - 1;

  logic [NUM_SECT-1:0] cfgEn, cfgHalt, cfgOddLo, cfgOddHi, sticky;
  logic [SEL_W-1:0]    accSect;
  logic                blkUpper;
  logic                errNow;
  logic                unusedWrBits;

  assign accSect      = accAddr[ADDR_W-1:SECT_LSB];
  assign blkUpper     = accAddr[BLK_BIT];
  assign errNow       = |laneErr;
  assign unusedWrBits = ^regWrData[BIT_STICKY-1:BIT_ODD_HI+1];

  always_comb begin
    strb.genEn    = parityStrap;
    strb.chkEn    = parityStrap & accValid & ~accWrite & cfgEn[accSect];
    strb.oddSense = blkUpper ? cfgOddHi[accSect] : cfgOddLo[accSect];
    strb.laneWe   = (accValid && accWrite) ? accByteEn : '0;
  end

  for (genvar g = 0; g < NUM_SECT; g++) begin : gSect
    logic selHit, errHit;
    assign selHit = regWrEn && (regSel == SEL_W'(g));
    assign errHit = errNow && (accSect == SEL_W'(g));
    always_ff @(posedge clk) begin
      if (!rstN) begin
        cfgEn[g]    <= 1'b0;
        cfgHalt[g]  <= 1'b0;
        cfgOddLo[g] <= 1'b0;
        cfgOddHi[g] <= 1'b0;
        sticky[g]   <= 1'b0;
      end else begin
        if (selHit) begin
          cfgEn[g]    <= regWrData[BIT_EN];
          cfgHalt[g]  <= regWrData[BIT_HALT];
          cfgOddLo[g] <= regWrData[BIT_ODD_LO];
          cfgOddHi[g] <= regWrData[BIT_ODD_HI];
          if (regWrData[BIT_STICKY]) sticky[g] <= 1'b0;
        end
        if (errHit) sticky[g] <= 1'b1;  // set wins over clear
      end
    end
  end

  always_comb begin
    regRdData             = '0;
    regRdData[BIT_EN]     = cfgEn[regSel];
    regRdData[BIT_HALT]   = cfgHalt[regSel];
    regRdData[BIT_ODD_LO] = cfgOddLo[regSel];
    regRdData[BIT_ODD_HI] = cfgOddHi[regSel];
    regRdData[BIT_STICKY] = sticky[regSel];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      haltReq <= 1'b0;
      trapReq <= 1'b0;
      errAddr <= '0;
    end else begin
      haltReq <= errNow & cfgHalt[accSect];
      trapReq <= errNow & ~cfgHalt[accSect];
      if (errNow) errAddr <= accAddr;
    end
  end

  p_req_exclusive_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(haltReq && trapReq));
  p_strap_off_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    !parityStrap |=> !(haltReq || trapReq));
  p_write_quiet_r5: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && accWrite) |=> !(haltReq || trapReq));
  p_disabled_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && !accWrite && !cfgEn[accSect]) |=> !(haltReq || trapReq));
  p_sticky_follows_r9: assert property (@(posedge clk) disable iff (!rstN)
    (haltReq || trapReq) |-> sticky[errAddr[ADDR_W-1:SECT_LSB]]);
  p_capture_addr_r10: assert property (@(posedge clk) disable iff (!rstN)
    (haltReq || trapReq) |-> errAddr == $past(accAddr));
endmodule

// File: rtl/parity_guard.sv
module parity_guard
  import parity_guard_pkg::*;
#(
  parameter int ADDR_W   = 17,
  parameter int NUM_SECT = 16
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        parityStrap,
  input  logic [$clog2(NUM_SECT)-1:0] regSel,
  input  logic                        regWrEn,
  input  logic [REG_W-1:0]            regWrData,
  output logic [REG_W-1:0]            regRdData,
  input  logic                        accValid,
  input  logic                        accWrite,
  input  logic [ADDR_W-1:0]           accAddr,
  input  logic [LANES-1:0]            accByteEn,
  input  logic [DATA_W-1:0]           accWrData,
  output logic [LANES-1:0]            memWe,
  output logic [LANES-1:0]            memWrPar,
  input  logic [DATA_W-1:0]           memRdData,
  input  logic [LANES-1:0]            memRdPar,
  output logic                        haltReq,
  output logic                        trapReq,
  output logic [ADDR_W-1:0]           errAddr
);
  dpStrobe_t        strb;
  logic [LANES-1:0] laneErr;

  parity_guard_ctrl #(.ADDR_W(ADDR_W), .NUM_SECT(NUM_SECT)) uCtrl (
    .clk(clk), .rstN(rstN), .parityStrap(parityStrap),
    .regSel(regSel), .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData),
    .accValid(accValid), .accWrite(accWrite), .accAddr(accAddr), .accByteEn(accByteEn),
    .laneErr(laneErr), .strb(strb),
    .haltReq(haltReq), .trapReq(trapReq), .errAddr(errAddr)
  );

  parity_guard_dp uDp (
    .strb(strb), .accWrData(accWrData), .memRdData(memRdData), .memRdPar(memRdPar),
    .memWe(memWe), .memWrPar(memWrPar), .laneErr(laneErr)
  );
endmodule

// File: tb/parity_guard_test.sv
module parity_guard_test;
  localparam int PERIOD = 10;
  localparam int NVEC   = 8;
  // {addr[16:0], data[15:0], byteEn[1:0], flip[1:0]}
  localparam logic [36:0] VEC [NVEC] = '{
    {17'h00010, 16'hA5A5, 2'b11, 2'b00},
    {17'h00020, 16'h0001, 2'b11, 2'b01},
    {17'h06005, 16'h00FF, 2'b11, 2'b10},
    {17'h07004, 16'h1234, 2'b11, 2'b00},
    {17'h0A100, 16'hFFFF, 2'b11, 2'b11},
    {17'h0D000, 16'h8000, 2'b11, 2'b01},
    {17'h1FFFF, 16'h7F01, 2'b11, 2'b11},
    {17'h19ABC, 16'hC3C3, 2'b01, 2'b00}
  };

  logic        clk = 0, rstN = 0, parityStrap = 1;
  logic [3:0]  regSel = 0;
  logic        regWrEn = 0;
  logic [15:0] regWrData = 0, regRdData;
  logic        accValid = 0, accWrite = 0;
  logic [16:0] accAddr = 0, errAddr;
  logic [1:0]  accByteEn = 0, memWe, memWrPar, memRdPar = 0;
  logic [15:0] accWrData = 0, memRdData = 0;
  logic        haltReq, trapReq;
  int          nChk = 0, nBad = 0;
  bit          finished = 0;

  parity_guard uut (.*);

  always #(PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] cfgFor(input int s);
    return {s[2], s[1], s[0], (s != 5)};  // {oddHi, oddLo, halt, en}
  endfunction

  function automatic logic [1:0] expPar(input logic [15:0] d, input logic odd);
    return {(^d[15:8]) ^ odd, (^d[7:0]) ^ odd};
  endfunction

  task automatic regWrite(input logic [3:0] sel, input logic [15:0] d);
    @(negedge clk); regSel = sel; regWrData = d; regWrEn = 1;
    @(negedge clk); regWrEn = 0;
  endtask

  task automatic regRead(input logic [3:0] sel, output logic [15:0] d);
    @(negedge clk); regSel = sel; #1 d = regRdData;
  endtask

  task automatic doWrite(input logic [16:0] a, input logic [15:0] d, input logic [1:0] be,
                         output logic [1:0] par, output logic [1:0] we);
    @(negedge clk); accValid = 1; accWrite = 1; accAddr = a; accWrData = d; accByteEn = be;
    #1 par = memWrPar; we = memWe;
    @(negedge clk); accValid = 0; accWrite = 0;
  endtask

  task automatic doRead(input logic [16:0] a, input logic [15:0] d, input logic [1:0] par,
                        output logic h, output logic t);
    @(negedge clk); accValid = 1; accWrite = 0; accAddr = a; memRdData = d; memRdPar = par;
    @(negedge clk); accValid = 0; h = haltReq; t = trapReq;
  endtask

  initial begin
    #(PERIOD * 100000);
    if (!finished) begin
      nChk++; nBad++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    logic [15:0] rd;
    logic [1:0]  par, we;
    logic        h, t;
    repeat (3) @(negedge clk);
    rstN = 1;

    // R1: reset state
    for (int s = 0; s < 16; s++) begin
      regRead(4'(s), rd);
      check(rd == 16'h0, "R1 reg reset", 32'(rd), 0);
    end
    check(!haltReq && !trapReq, "R1 requests low", {haltReq, trapReq}, 0);
    check(errAddr == 0, "R1 errAddr", 32'(errAddr), 0);

    // R2: layout and readback
    regWrite(4'd9, 16'h7FFF);
    regRead(4'd9, rd);
    check(rd == 16'h000F, "R2 reserved bits read 0", 32'(rd), 32'h000F);
    regWrite(4'd9, 16'h0006);
    regRead(4'd9, rd);
    check(rd == 16'h0006, "R2 readback", 32'(rd), 32'h0006);

    for (int s = 0; s < 16; s++) regWrite(4'(s), {12'h0, cfgFor(s)});

    // Vector table: R3 R4 R5 R6 R7 R10
    for (int i = 0; i < NVEC; i++) begin
      logic [16:0] a;
      logic [15:0] d;
      logic [1:0]  be, fl, ePar;
      logic [3:0]  c;
      logic        odd, eErr;
      {a, d, be, fl} = VEC[i];
      c    = cfgFor(int'(a[16:13]));
      odd  = a[12] ? c[3] : c[2];
      ePar = expPar(d, odd);
      doWrite(a, d, be, par, we);
      check(par == ePar, "R3 write parity", 32'(par), 32'(ePar));
      check(we == be, "R4 lane strobes", 32'(we), 32'(be));
      doRead(a, d, par ^ fl, h, t);
      eErr = c[0] && (fl != 0);
      check(h == (eErr && c[1]), "R6 halt request", 32'(h), 32'(eErr && c[1]));
      check(t == (eErr && !c[1]), c[0] ? "R5 trap request" : "R7 disabled section",
            32'(t), 32'(eErr && !c[1]));
      if (eErr) check(errAddr == a, "R10 errAddr", 32'(errAddr), 32'(a));
    end

    // R9: sticky flag
    regRead(4'd0, rd);
    check(rd == 16'h8001, "R9 sticky set", 32'(rd), 32'h8001);
    regWrite(4'd0, 16'h0001);
    regRead(4'd0, rd);
    check(rd == 16'h8001, "R9 write 0 keeps", 32'(rd), 32'h8001);
    regWrite(4'd0, 16'h8001);
    regRead(4'd0, rd);
    check(rd == 16'h0001, "R9 write 1 clears", 32'(rd), 32'h0001);
    @(negedge clk);
    regSel = 0; regWrData = 16'h8001; regWrEn = 1;
    accValid = 1; accWrite = 0; accAddr = 17'h00033; memRdData = 16'h0000; memRdPar = 2'b01;
    @(negedge clk); regWrEn = 0; accValid = 0;
    check(trapReq, "R9 trap in same cycle", 32'(trapReq), 1);
    regRead(4'd0, rd);
    check(rd == 16'h8001, "R9 set wins over clear", 32'(rd), 32'h8001);
    regWrite(4'd0, 16'h8001);

    // R11: sense change after write
    doWrite(17'h00040, 16'h0003, 2'b11, par, we);
    doRead(17'h00040, 16'h0003, par, h, t);
    check(!h && !t, "R11 clean before change", {h, t}, 0);
    regWrite(4'd0, 16'h0005);
    doRead(17'h00040, 16'h0003, par, h, t);
    check(t && !h, "R11 error after sense flip", {h, t}, 32'b01);
    check(errAddr == 17'h00040, "R10 errAddr after flip", 32'(errAddr), 32'h40);
    doRead(17'h01040, 16'h0003, par, h, t);
    check(!h && !t, "R11 other half unaffected", {h, t}, 0);

    // R8: strap off
    regWrite(4'd2, 16'h8005);
    parityStrap = 0;
    doWrite(17'h04010, 16'h0001, 2'b11, par, we);
    check(par == 2'b00, "R8 no parity generated", 32'(par), 0);
    doRead(17'h04010, 16'h0001, 2'b10, h, t);
    check(!h && !t, "R8 no request", {h, t}, 0);
    regRead(4'd2, rd);
    check(rd == 16'h0005, "R8 sticky untouched", 32'(rd), 32'h0005);
    parityStrap = 1;

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule